// File: doc/BRIEF.md
# Five-Stage Pipelined RISC Core

This block is an in-order 32-bit processor core for a small load/store instruction subset. It runs the register-to-register operations add, subtract, and, or and set-less-than, plus word load, word store and branch-if-equal. Each instruction moves through five stages: fetch, decode with register read, execute or address calculation, memory access, and write back. Four pipeline registers separate the stages, and each of these registers holds everything a later stage of the instruction can need. The destination register number and the store data travel with the instruction, so write back always uses the retiring instruction's own destination.

The core has no hazard logic of any kind. There is no forwarding, no stall and no flush. Programs must space dependent instructions with no-ops. The register file passes a value written in a cycle to a read of the same register in that cycle, so an instruction may read a result three slots after the instruction that produced it. A taken branch redirects fetch once it reaches the memory stage, so the three instructions that follow it always execute.

The instruction memory and the data memory are internal word arrays. A loader port writes them, and two peek ports read back one register and one data word, each with one cycle of latency. The loader is normally used while reset is held.

Top module: `pipe_core`

## Requirements
- R1: Reset sets the PC to byte address 0. The PC always stays word aligned, and at each clock edge it advances by 4 unless a taken branch redirects it.
- R2: beq (opcode 0x04) compares rs (bits 25:21) with rt (bits 20:16). When they are equal, the PC becomes the beq address + 4 + (sign-extended bits 15:0 shifted left by 2). The redirect takes effect at the edge that ends the branch's memory stage, and the three instructions after the branch still execute.
- R3: A beq whose operands differ does not change the sequential flow.
- R4: Opcode 0x00 selects a register-register operation by its function field (bits 5:0): 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A signed set-less-than. The result goes to rd (bits 15:11). Any other function code writes zero.
- R5: lw (opcode 0x23) loads the data word at address rs + sign-extended bits 15:0 into rt. Negative offsets are supported.
- R6: sw (opcode 0x2B) writes rt to the data word at address rs + sign-extended bits 15:0, and it changes no register.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: A register read in decode during the same cycle that write back writes that register returns the new value. This includes the peek port.
- R9: Write back uses the destination number that was captured with its own instruction in decode.
- R10: With ld_en high, ld_data is written at the rising edge to word ld_addr, in data memory when ld_dmem is 1 and in instruction memory when it is 0. peek_reg_data and peek_mem_data show the selected register or data word one cycle after the address is applied.
- R11: Reset clears all 32 registers and empties the pipeline. Memory contents are kept through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Loader write strobe |
| ld_dmem | input | 1 | Loader target: 1 data memory, 0 instruction memory |
| ld_addr | input | LD_AW | Loader word index |
| ld_data | input | 32 | Loader write word |
| peek_reg | input | 5 | Register number to observe |
| peek_reg_data | output | 32 | Registered value of the observed register |
| peek_mem | input | DM_AW | Data memory word index to observe |
| peek_mem_data | output | 32 | Registered value of the observed data word |

## Verification
Properties checked on every clock cycle cover:
- PC sequencing and alignment, and the redirect to the computed branch target.
- The zero register reading as zero.
- The same-cycle write-to-read pass-through.
- Stores never asserting a register write.
- The write-back destination matching the number that moved through the previous pipeline register.

Only the bench's program run can show the final architectural state:
- The arithmetic results.
- Load and store addressing with negative offsets.
- The fact that the three slots after a branch execute while the instruction after them is skipped.
- Not-taken branches.
- Memory surviving reset.

// File: rtl/pipe_pkg.sv
package pipe_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;
  localparam logic [5:0] OPC_BREQ = 6'h04;

  localparam logic [5:0] FC_ADD = 6'h20;
  localparam logic [5:0] FC_SUB = 6'h22;
  localparam logic [5:0] FC_AND = 6'h24;
  localparam logic [5:0] FC_OR  = 6'h25;
  localparam logic [5:0] FC_SLT = 6'h2A;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } aop_e;

  typedef enum logic [2:0] {
    ALU_AND  = 3'd0,
    ALU_OR   = 3'd1,
    ALU_ADD  = 3'd2,
    ALU_SUB  = 3'd3,
    ALU_SLT  = 3'd4,
    ALU_ZERO = 3'd5
  } alu_fn_e;

  typedef struct packed {
    aop_e op;
    logic use_imm;
  } ex_ctl_t;

  typedef struct packed {
    logic branch;
    logic rd_en;
    logic wr_en;
  } mem_ctl_t;

  typedef struct packed {
    logic from_mem;
    logic wr_en;
  } wb_ctl_t;

  typedef struct packed {
    logic     dst_rd;
    ex_ctl_t  ex;
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } ctl_t;

  typedef struct packed {
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] instr;
  } fd_reg_t;

  typedef struct packed {
    ex_ctl_t         ex;
    mem_ctl_t        mem;
    wb_ctl_t         wb;
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] imm;
    logic [4:0]      dst;
    logic [5:0]      fc;
  } de_reg_t;

  typedef struct packed {
    mem_ctl_t        mem;
    wb_ctl_t         wb;
    logic [XLEN-1:0] target;
    logic            eq;
    logic [XLEN-1:0] y;
    logic [XLEN-1:0] sdata;
    logic [4:0]      dst;
  } em_reg_t;

  typedef struct packed {
    wb_ctl_t         wb;
    logic [XLEN-1:0] y;
    logic [4:0]      dst;
  } mw_reg_t;

endpackage

// File: rtl/pipe_ctrl.sv
module pipe_ctrl
  import pipe_pkg::*;
(
  input  logic [5:0] opcode,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    case (opcode)
      OPC_REG: begin
        ctl.dst_rd    = 1'b1;
        ctl.ex.op     = AOP_FUNCT;
        ctl.wb.wr_en  = 1'b1;
      end
      OPC_LOAD: begin
        ctl.ex.use_imm   = 1'b1;
        ctl.mem.rd_en    = 1'b1;
        ctl.wb.from_mem  = 1'b1;
        ctl.wb.wr_en     = 1'b1;
      end
      OPC_STOR: begin
        ctl.ex.use_imm = 1'b1;
        ctl.mem.wr_en  = 1'b1;
      end
      OPC_BREQ: begin
        ctl.ex.op      = AOP_SUB;
        ctl.mem.branch = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  output logic [W-1:0]  rd3,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  function automatic logic [W-1:0] rd_port(input logic [AW-1:0] ra);
    if (ra == '0)               return '0;
    else if (we && wa == ra)    return wd;
    else                        return regs[ra];
  endfunction

  assign rd1 = rd_port(ra1);
  assign rd2 = rd_port(ra2);
  assign rd3 = rd_port(ra3);
endmodule

// File: rtl/pipe_alu.sv
module pipe_alu
  import pipe_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         eq
);
  always_comb begin
    case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign eq = (a == b);
endmodule

// File: rtl/pipe_core.sv
module pipe_core
  import pipe_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IM_AW = $clog2(IMEM_WORDS),
  localparam int DM_AW = $clog2(DMEM_WORDS),
  localparam int LD_AW = (IM_AW > DM_AW) ? IM_AW : DM_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [31:0]      ld_data,
  input  logic [4:0]       peek_reg,
  output logic [31:0]      peek_reg_data,
  input  logic [DM_AW-1:0] peek_mem,
  output logic [31:0]      peek_mem_data
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc;
  logic            pc_src;
  fd_reg_t fd;
  de_reg_t de;
  em_reg_t em;
  mw_reg_t mw;
  logic [XLEN-1:0] mw_ld;

  // ---------------- fetch
  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_addr[IM_AW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      fd <= '0;
    end else begin
      pc       <= pc_src ? em.target : pc + 32'd4;
      fd.pc4   <= pc + 32'd4;
      fd.instr <= imem[pc[IM_AW+1:2]];
    end
  end

  // ---------------- decode
  ctl_t            ctl;
  logic [4:0]      rs_n, rt_n;
  logic [XLEN-1:0] rs_v, rt_v, rf_peek;
  logic            wb_we;
  logic [4:0]      wb_wa;
  logic [XLEN-1:0] wb_wd;

  assign rs_n = fd.instr[25:21];
  assign rt_n = fd.instr[20:16];

  pipe_ctrl u_ctrl (.opcode(fd.instr[31:26]), .ctl(ctl));

  pipe_regfile #(.W(XLEN), .NREG(32)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(rs_n), .ra2(rt_n), .ra3(peek_reg),
    .rd1(rs_v), .rd2(rt_v), .rd3(rf_peek),
    .we(wb_we), .wa(wb_wa), .wd(wb_wd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      de <= '0;
    end else begin
      de.ex  <= ctl.ex;
      de.mem <= ctl.mem;
      de.wb  <= ctl.wb;
      de.pc4 <= fd.pc4;
      de.a   <= rs_v;
      de.b   <= rt_v;
      de.imm <= {{16{fd.instr[15]}}, fd.instr[15:0]};
      de.dst <= ctl.dst_rd ? fd.instr[15:11] : rt_n;
      de.fc  <= fd.instr[5:0];
    end
  end

  // ---------------- execute
  alu_fn_e         fn;
  logic [XLEN-1:0] alu_b, alu_y;
  logic            alu_eq;

  always_comb begin
    case (de.ex.op)
      AOP_ADD: fn = ALU_ADD;
      AOP_SUB: fn = ALU_SUB;
      AOP_FUNCT: begin
        case (de.fc)
          FC_ADD:  fn = ALU_ADD;
          FC_SUB:  fn = ALU_SUB;
          FC_AND:  fn = ALU_AND;
          FC_OR:   fn = ALU_OR;
          FC_SLT:  fn = ALU_SLT;
          default: fn = ALU_ZERO;
        endcase
      end
      default: fn = ALU_ZERO;
    endcase
  end

  assign alu_b = de.ex.use_imm ? de.imm : de.b;

  pipe_alu #(.W(XLEN)) u_alu (.fn(fn), .a(de.a), .b(alu_b), .y(alu_y), .eq(alu_eq));

  always_ff @(posedge clk) begin
    if (rst) begin
      em <= '0;
    end else begin
      em.mem    <= de.mem;
      em.wb     <= de.wb;
      em.target <= de.pc4 + {de.imm[XLEN-3:0], 2'b00};
      em.eq     <= alu_eq;
      em.y      <= alu_y;
      em.sdata  <= de.b;
      em.dst    <= de.dst;
    end
  end

  // ---------------- memory
  logic             dm_we;
  logic [DM_AW-1:0] dm_wa;
  logic [XLEN-1:0]  dm_wd;

  assign pc_src = em.mem.branch & em.eq;
  assign dm_we  = (ld_en && ld_dmem) || em.mem.wr_en;
  assign dm_wa  = (ld_en && ld_dmem) ? ld_addr[DM_AW-1:0] : em.y[DM_AW+1:2];
  assign dm_wd  = (ld_en && ld_dmem) ? ld_data : em.sdata;

  always_ff @(posedge clk) begin
    if (dm_we) dmem[dm_wa] <= dm_wd;
  end

  always_ff @(posedge clk) begin
    if (em.mem.rd_en) mw_ld <= dmem[em.y[DM_AW+1:2]];
  end

  always_ff @(posedge clk) begin
    peek_mem_data <= dmem[peek_mem];
    peek_reg_data <= rf_peek;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mw <= '0;
    end else begin
      mw.wb  <= em.wb;
      mw.y   <= em.y;
      mw.dst <= em.dst;
    end
  end

  // ---------------- write back
  assign wb_we = mw.wb.wr_en;
  assign wb_wa = mw.dst;
  assign wb_wd = mw.wb.from_mem ? mw_ld : mw.y;
endmodule

// File: rtl/pipe_core_chk.sv
module pipe_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        pc_src,
  input logic [31:0] br_target,
  input logic [4:0]  dec_rs,
  input logic [31:0] dec_rs_val,
  input logic        em_mem_wr,
  input logic        em_reg_wr,
  input logic [4:0]  em_dst,
  input logic        mw_reg_wr,
  input logic [4:0]  mw_dst,
  input logic [31:0] wb_wd
);
  logic prev_run;
  always_ff @(posedge clk) prev_run <= !rst;

  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (prev_run && !$past(pc_src)) |-> pc == $past(pc) + 32'd4);

  // R1
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  // R2
  pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (prev_run && $past(pc_src)) |-> pc == $past(br_target));

  // R7
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_rs == 5'd0) |-> dec_rs_val == 32'd0);

  // R8
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (mw_reg_wr && mw_dst == dec_rs && dec_rs != 5'd0) |-> dec_rs_val == wb_wd);

  // R6
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    em_mem_wr |-> !em_reg_wr);

  // R9
  wb_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (prev_run && mw_reg_wr) |-> mw_dst == $past(em_dst));
endmodule

bind pipe_core pipe_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .pc_src(pc_src), .br_target(em.target),
  .dec_rs(rs_n), .dec_rs_val(rs_v),
  .em_mem_wr(em.mem.wr_en), .em_reg_wr(em.wb.wr_en), .em_dst(em.dst),
  .mw_reg_wr(mw.wb.wr_en), .mw_dst(mw.dst), .wb_wd(wb_wd)
);

// File: tb/pipe_core_bench.sv
module pipe_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0, ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  peek_reg = '0;
  logic [31:0] peek_reg_data;
  logic [5:0]  peek_mem = '0;
  logic [31:0] peek_mem_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_core u_pipe_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_data(ld_data), .peek_reg(peek_reg), .peek_reg_data(peek_reg_data),
    .peek_mem(peek_mem), .peek_mem_data(peek_mem_data)
  );

  function automatic logic [31:0] rt_ins(input logic [5:0] fc, input logic [4:0] s,
                                         input logic [4:0] t, input logic [4:0] d);
    return {6'h00, s, t, d, 5'd0, fc};
  endfunction
  function automatic logic [31:0] im_ins(input logic [5:0] op, input logic [4:0] s,
                                         input logic [4:0] t, input logic [15:0] imm);
    return {op, s, t, imm};
  endfunction

  localparam logic [31:0] NOP = 32'h0;
  localparam logic [31:0] PROG [31] = '{
    im_ins(6'h23, 0, 1, 16'd0),         // 0  lw r1,0(r0)
    im_ins(6'h23, 0, 2, 16'd4),         // 1  lw r2,4(r0)
    im_ins(6'h23, 0, 3, 16'd8),         // 2  lw r3,8(r0)
    NOP,                                // 3
    rt_ins(6'h20, 1, 2, 4),             // 4  add r4 (r2 at distance 3)
    rt_ins(6'h22, 1, 2, 5),             // 5  sub r5
    rt_ins(6'h24, 2, 3, 6),             // 6  and r6
    rt_ins(6'h25, 1, 3, 7),             // 7  or  r7
    rt_ins(6'h2A, 3, 1, 8),             // 8  slt r8
    rt_ins(6'h2A, 1, 3, 9),             // 9  slt r9
    im_ins(6'h2B, 0, 4, 16'd16),        // 10 sw r4,16(r0)
    im_ins(6'h2B, 2, 5, 16'hFFFC),      // 11 sw r5,-4(r2)
    im_ins(6'h23, 0, 10, 16'd16),       // 12 lw r10,16(r0)
    im_ins(6'h04, 1, 1, 16'd4),         // 13 beq r1,r1 -> 18
    NOP, NOP, NOP,                      // 14..16 execute
    rt_ins(6'h20, 1, 1, 11),            // 17 skipped
    rt_ins(6'h20, 1, 1, 12),            // 18 target
    im_ins(6'h04, 1, 2, 16'd4),         // 19 beq r1,r2 not taken
    NOP, NOP, NOP,                      // 20..22
    rt_ins(6'h20, 2, 2, 13),            // 23 add r13
    rt_ins(6'h20, 1, 1, 0),             // 24 add r0 (discarded)
    NOP, NOP,                           // 25..26
    rt_ins(6'h20, 0, 1, 14),            // 27 add r14,r0,r1
    im_ins(6'h2B, 0, 1, 16'd20),        // 28 sw r1,20(r0)
    NOP,                                // 29
    im_ins(6'h04, 0, 0, 16'hFFFF)       // 30 spin
  };

  localparam logic [31:0] DINIT [4] = '{32'd5, 32'd12, 32'hFFFF_FFFD, 32'd7};

  localparam logic [31:0] EXP_REG [16] = '{
    32'd0, 32'd5, 32'd12, 32'hFFFF_FFFD, 32'd17, 32'hFFFF_FFF9, 32'd12, 32'hFFFF_FFFD,
    32'd1, 32'd0, 32'd17, 32'd0, 32'd10, 32'd24, 32'd5, 32'd0
  };
  localparam logic [31:0] EXP_MEM [6] = '{
    32'd5, 32'd12, 32'hFFFF_FFF9, 32'd7, 32'd17, 32'd5
  };

  function automatic string reg_tag(input int i);
    case (i)
      0:       return "R7 r0 discard";
      1:       return "R6 R9 lw r1 untouched by sw";
      2:       return "R5 lw r2";
      3:       return "R5 lw r3";
      4:       return "R4 R8 add";
      5:       return "R4 sub";
      6:       return "R4 and";
      7:       return "R4 or";
      8, 9:    return "R4 slt";
      10:      return "R6 R5 store then load";
      11:      return "R2 skipped after slots";
      12:      return "R2 branch target";
      13:      return "R3 not taken";
      14:      return "R7 R8 r0 reads zero";
      default: return "R11 untouched reg";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic dm, input int a, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_dmem = dm; ld_addr = 6'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic read_reg(input int r, output logic [31:0] v);
    @(negedge clk); peek_reg = 5'(r);
    @(posedge clk); @(negedge clk); v = peek_reg_data;
  endtask

  task automatic read_mem(input int a, output logic [31:0] v);
    @(negedge clk); peek_mem = 6'(a);
    @(posedge clk); @(negedge clk); v = peek_mem_data;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 64; i++) load(1'b0, i, (i < 31) ? PROG[i] : NOP);
    for (int i = 0; i < 4; i++) load(1'b1, i, DINIT[i]);
    for (int i = 4; i < 8; i++) load(1'b1, i, 32'd0);

    // reset state and loader readback
    for (int r = 1; r < 4; r++) begin
      read_reg(r, v); check("R11 reg zero in reset", v, 32'd0);
    end
    for (int i = 0; i < 4; i++) begin
      read_mem(i, v); check("R10 dmem preload", v, DINIT[i]);
    end

    @(negedge clk); rst = 1'b0;
    repeat (80) @(posedge clk);

    for (int r = 0; r < 16; r++) begin
      read_reg(r, v); check(reg_tag(r), v, EXP_REG[r]);
    end
    for (int i = 0; i < 6; i++) begin
      read_mem(i, v); check((i == 2) ? "R5 R6 negative offset store" : "R6 dmem", v, EXP_MEM[i]);
    end

    // directed: reset clears registers but keeps memory
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    read_reg(4, v);  check("R11 reg cleared", v, 32'd0);
    read_mem(4, v);  check("R11 memory kept", v, 32'd17);
    read_reg(12, v); check("R11 reg cleared", v, 32'd0);

    done = 1;
    finish_run();
  end
endmodule